// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake inputs (clear to send, data set ready, ring indicator and carrier detect) and reports them to a serial port controller. It publishes the current asserted level of each line and a sticky change flag for each line. The flags accumulate until software reads the status byte. A request line goes high whenever the modem-status interrupt is enabled and any change flag is pending.

Each input is resynchronised to the local clock before any edge is detected. Three lines flag a change on either edge. The ring indicator flags only the end of a ring, when its pin goes from low to high. For diagnostics, a loopback mode disconnects the external pins. Request-to-send, terminal-ready and two spare control bits are then fed back into the detector, and the block's own control output pins are parked in their inactive (high) state.

Top module: `modem_stat_det`

## Requirements
- R1: While reset is asserted and right after it, `stat_o` is 8'h00, `irq_o` is 0, and with all control bits at 0 every control output pin is 1.
- R2: `stat_o[7:4]` hold the complement of the effective clear-to-send, data-set-ready, ring and carrier-detect pins (bit 4, 5, 6, 7 respectively), visible two clock edges after the pin changes.
- R3: `stat_o[0]` (clear to send), `stat_o[1]` (data set ready) and `stat_o[3]` (carrier detect) set on either edge of their pin, one edge after the level bit changes, and stay set.
- R4: `stat_o[2]` sets only when the ring pin goes low to high (level bit 6 falls); a high-to-low pin change leaves it unchanged.
- R5: A cycle with `stat_rd` high clears all four change bits at the next edge; a change detected at that same edge still sets its bit.
- R6: `irq_o` is high exactly when `msi_en` is 1 and at least one of `stat_o[3:0]` is 1.
- R7: With `loop_en` at 1, the effective pins are the complements of `rts_ctl` (to clear to send), `dtr_ctl` (to data set ready), `aux1_ctl` (to ring) and `aux2_ctl` (to carrier detect).
- R8: With `loop_en` at 0, each control output pin is the complement of its control bit; with `loop_en` at 1, all four are held at 1.
- R9: With `loop_en` at 1, changes on the four external input pins change neither the level bits nor the change bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring indicator pin, active low |
| dcd_n_i | input | 1 | Carrier-detect pin, active low |
| loop_en | input | 1 | Loopback mode select |
| rts_ctl | input | 1 | Request-to-send control bit |
| dtr_ctl | input | 1 | Terminal-ready control bit |
| aux1_ctl | input | 1 | Spare control bit 1 |
| aux2_ctl | input | 1 | Spare control bit 2 |
| msi_en | input | 1 | Modem-status interrupt enable |
| stat_rd | input | 1 | Status read strobe, one cycle |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| dtr_n_o | output | 1 | Terminal-ready pin, active low |
| aux1_n_o | output | 1 | Spare output pin 1, active low |
| aux2_n_o | output | 1 | Spare output pin 2, active low |
| stat_o | output | 8 | Levels [7:4], change flags [3:0] |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A status read clearing the change flags and a fresh pin change setting one can land on the same clock edge. The bench provokes this by raising `stat_rd` in the cycle after the new level first appears, one edge before that change is flagged. It then expects the status sampled during the read to show the new level with only the old flags. After the read, it expects only the new change's bit to survive.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int NLINES = 4;
  // line index inside every 4-bit vector
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
  // lines whose change flag is set only on a rising pin
  localparam logic [NLINES-1:0] TRAIL_ONLY = 4'b0100;

  typedef struct packed {
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] dlt;
  } mstat_t;
endpackage

// File: rtl/msd_rst_sync.sv
module msd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stg_d[g] = d_i;
    end else begin : g_next
      always_comb stg_d[g] = stg_q[g-1];
    end
    // pins idle high, so reset to the inactive level
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '1;
      else        stg_q[g] <= stg_d[g];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/msd_delta.sv
module msd_delta #(
  parameter int          W     = 4,
  parameter logic [W-1:0] TRAIL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic         clr,
  output logic [W-1:0] dlt_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] dlt_q;
  logic [W-1:0] chg;
  logic [W-1:0] dlt_d;

  for (genvar g = 0; g < W; g++) begin : g_edge
    if (TRAIL[g]) begin : g_rise
      always_comb chg[g] = pin_s[g] & ~prev_q[g];
    end else begin : g_any
      always_comb chg[g] = pin_s[g] ^ prev_q[g];
    end
  end

  always_comb begin
    dlt_d = (clr ? '0 : dlt_q) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      dlt_q  <= '0;
    end else begin
      prev_q <= pin_s;
      dlt_q  <= dlt_d;
    end
  end

  assign dlt_o = dlt_q;
endmodule

// File: rtl/modem_stat_det.sv
module modem_stat_det #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       dcd_n_i,
  input  logic       loop_en,
  input  logic       rts_ctl,
  input  logic       dtr_ctl,
  input  logic       aux1_ctl,
  input  logic       aux2_ctl,
  input  logic       msi_en,
  input  logic       stat_rd,
  output logic       rts_n_o,
  output logic       dtr_n_o,
  output logic       aux1_n_o,
  output logic       aux2_n_o,
  output logic [7:0] stat_o,
  output logic       irq_o
);
  import msd_pkg::*;

  logic              rst_n_s;
  logic [NLINES-1:0] ext_n;
  logic [NLINES-1:0] ctl;
  logic [NLINES-1:0] src_n;
  logic [NLINES-1:0] pin_s;
  logic [NLINES-1:0] dlt;
  mstat_t            stat;

  msd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    ext_n[LN_CTS] = cts_n_i;
    ext_n[LN_DSR] = dsr_n_i;
    ext_n[LN_RI]  = ri_n_i;
    ext_n[LN_DCD] = dcd_n_i;
    ctl[LN_CTS]   = rts_ctl;
    ctl[LN_DSR]   = dtr_ctl;
    ctl[LN_RI]    = aux1_ctl;
    ctl[LN_DCD]   = aux2_ctl;
    src_n         = loop_en ? ~ctl : ext_n;
  end

  // outputs parked inactive while looped back
  always_comb begin
    rts_n_o  = loop_en | ~rts_ctl;
    dtr_n_o  = loop_en | ~dtr_ctl;
    aux1_n_o = loop_en | ~aux1_ctl;
    aux2_n_o = loop_en | ~aux2_ctl;
  end

  msd_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(src_n), .q_o(pin_s)
  );

  msd_delta #(.W(NLINES), .TRAIL(TRAIL_ONLY)) u_delta (
    .clk(clk), .rst_n(rst_n_s), .pin_s(pin_s), .clr(stat_rd), .dlt_o(dlt)
  );

  always_comb begin
    stat.lvl = ~pin_s;
    stat.dlt = dlt;
    stat_o   = stat;
    irq_o    = msi_en & (|dlt);
  end
endmodule

// File: rtl/msd_chk.sv
module msd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loop_en,
  input logic       msi_en,
  input logic       stat_rd,
  input logic       rts_n_o,
  input logic       dtr_n_o,
  input logic       aux1_n_o,
  input logic       aux2_n_o,
  input logic [7:0] stat_o,
  input logic       irq_o
);
  // R3
  cts_flag_follows_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[0]) |-> ($past(stat_o[4]) != $past(stat_o[4], 2)));

  // R4
  ring_flag_trailing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[2]) |-> ($past(stat_o[6], 2) && !$past(stat_o[6])));

  // R5
  flags_fall_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat_o[3:0]) & ~stat_o[3:0])) |-> $past(stat_rd));

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq_o);

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|stat_o[3:0]));

  // R8
  loop_outputs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rts_n_o && dtr_n_o && aux1_n_o && aux2_n_o));
endmodule

bind modem_stat_det msd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .msi_en(msi_en),
  .stat_rd(stat_rd), .rts_n_o(rts_n_o), .dtr_n_o(dtr_n_o),
  .aux1_n_o(aux1_n_o), .aux2_n_o(aux2_n_o), .stat_o(stat_o), .irq_o(irq_o)
);

// File: tb/sim_modem_stat_det.sv
module sim_modem_stat_det;
  logic clk;
  logic rst_n;
  logic [3:0] ext_n;   // 0 cts, 1 dsr, 2 ri, 3 dcd
  logic [3:0] ctl;     // 0 rts, 1 dtr, 2 aux1, 3 aux2
  logic loop_en, msi_en, stat_rd;
  logic rts_n_o, dtr_n_o, aux1_n_o, aux2_n_o, irq_o;
  logic [7:0] stat_o;

  typedef struct {
    string      req;
    logic [7:0] stat;
    logic       irq;
    logic [3:0] pins;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0] lvl_m, dlt_m, prev_m;

  modem_stat_det u0 (
    .clk(clk), .rst_n(rst_n),
    .cts_n_i(ext_n[0]), .dsr_n_i(ext_n[1]), .ri_n_i(ext_n[2]), .dcd_n_i(ext_n[3]),
    .loop_en(loop_en), .rts_ctl(ctl[0]), .dtr_ctl(ctl[1]),
    .aux1_ctl(ctl[2]), .aux2_ctl(ctl[3]), .msi_en(msi_en), .stat_rd(stat_rd),
    .rts_n_o(rts_n_o), .dtr_n_o(dtr_n_o), .aux1_n_o(aux1_n_o), .aux2_n_o(aux2_n_o),
    .stat_o(stat_o), .irq_o(irq_o)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [3:0] eff_pins();
    return loop_en ? ~ctl : ext_n;
  endfunction

  task automatic push(string req);
    exp_t e;
    e.req  = req;
    e.stat = {lvl_m, dlt_m};
    e.irq  = msi_en & (|dlt_m);
    e.pins = loop_en ? 4'hF : ~ctl;
    q.push_back(e);
  endtask

  task automatic model_change(output logic [3:0] newbits);
    logic [3:0] p, chg, rise;
    p = eff_pins();
    chg = p ^ prev_m;
    rise = p & ~prev_m;
    newbits = {chg[3], rise[2], chg[1], chg[0]};
    lvl_m = ~p;
    prev_m = p;
  endtask

  // drive inputs at a falling edge, wait for the flag edge, push expectation
  task automatic drive(input logic [3:0] e, input logic [3:0] c,
                       input logic lp, input logic en, input string req);
    logic [3:0] nb;
    @(negedge clk);
    ext_n = e; ctl = c; loop_en = lp; msi_en = en;
    model_change(nb);
    dlt_m = dlt_m | nb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    push(req);
  endtask

  task automatic read_stat(input string req);
    @(negedge clk);
    stat_rd = 1;
    push(req);
    @(negedge clk);
    stat_rd = 0;
    dlt_m = '0;
    push(req);
  endtask

  // read lands on the edge that flags a new change
  task automatic read_collide(input logic [3:0] e, input string req);
    logic [3:0] nb;
    @(negedge clk);
    ext_n = e;
    model_change(nb);
    repeat (2) @(posedge clk);
    @(negedge clk);
    stat_rd = 1;
    push(req);              // new level, old flags
    @(negedge clk);
    stat_rd = 0;
    dlt_m = nb;             // only the colliding change survives
    push(req);
  endtask

  // monitor: compare queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (stat_o !== e.stat || irq_o !== e.irq ||
            {aux2_n_o, aux1_n_o, dtr_n_o, rts_n_o} !== e.pins) begin
          fails++;
          $display("FAIL %s: stat=%h irq=%b pins=%b expected stat=%h irq=%b pins=%b",
                   e.req, stat_o, irq_o, {aux2_n_o, aux1_n_o, dtr_n_o, rts_n_o},
                   e.stat, e.irq, e.pins);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ext_n = 4'hF; ctl = 4'h0; loop_en = 0; msi_en = 0; stat_rd = 0;
    lvl_m = 0; dlt_m = 0; prev_m = 4'hF;
    repeat (3) @(negedge clk);
    push("R1 in reset");
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    push("R1 after reset");
    // R2 R3 R6: clear to send asserted, interrupt enabled
    drive(4'b1110, 4'h0, 0, 1, "R2 R3 R6 cts low");
    read_stat("R5 read clears");
    // R4: ring start sets only the level
    drive(4'b1010, 4'h0, 0, 1, "R4 ring start no flag");
    drive(4'b1110, 4'h0, 0, 1, "R4 ring end flags");
    // R6: disabled interrupt with a pending flag
    drive(4'b1110, 4'h0, 0, 0, "R6 enable off");
    read_stat("R5 read second");
    // R3: data set ready and carrier detect, both edges
    drive(4'b0100, 4'h0, 0, 1, "R3 dsr dcd fall");
    read_stat("R5 read third");
    drive(4'b1110, 4'h0, 0, 1, "R3 dsr dcd rise");
    read_stat("R5 read fourth");
    // R5: read on the edge of a new carrier-detect change
    read_collide(4'b0110, "R5 collide");
    read_stat("R5 read after collide");
    // R8: normal outputs follow control bits
    drive(4'b0110, 4'b1010, 0, 1, "R8 outputs normal");
    // R7 R8: loopback, all controls off -> all pins inactive
    drive(4'b0110, 4'h0, 1, 1, "R7 R8 enter loop");
    read_stat("R5 read in loop");
    drive(4'b0110, 4'b0001, 1, 1, "R7 rts to cts");
    drive(4'b0110, 4'b1111, 1, 1, "R7 all controls");
    read_stat("R5 read loop all");
    // R9: external pins toggled in loopback are ignored
    drive(4'b1001, 4'b1111, 1, 1, "R9 ext ignored");
    drive(4'b0000, 4'b1111, 1, 1, "R9 ext ignored again");
    drive(4'b0000, 4'b1011, 1, 1, "R7 R4 aux1 ring end");
    drive(4'b0000, 4'b1011, 0, 1, "R8 leave loop");
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule